// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels is served next. Each channel can be requested in two ways: by a device request line, or by a bit in a software request register. A mask register blocks any channel whose bit is set. The remaining requests are ORed into a `pending` output, which tells the timing controller to ask the processor for the bus.

When hold acknowledge arrives while a request is pending, the arbiter latches the winner. Channel 0 has the highest priority and the highest-numbered channel the lowest. The arbiter then drives a one-hot acknowledge to that device and keeps the grant for the whole service, even if a higher-priority request appears meanwhile. The timing controller ends the service with a one-cycle done strobe. That strobe releases the grant and clears the served channel's software request bit.

Top module: `dma_chan_arb`

## Requirements
- R1: Reset sets every mask bit, clears the software request register and drives all acknowledges low, so `pending` stays low even with device requests asserted.
- R2: A channel whose mask bit is 1 has no effect: it does not raise `pending` and is never granted. A mask write (`mask_load`) takes effect from the next clock edge.
- R3: When a grant is taken, the lowest-numbered channel with an unmasked request wins.
- R4: A 1 on bit n of `sw_req_set` sets software request bit n from the next edge. That bit then acts like a device request on channel n. It is cleared in the cycle the service of channel n ends, unless it is set again in the same cycle.
- R5: During a service, `dev_ack` and `grant_idx` do not change until `svc_done`. A new higher-priority request, the withdrawal of the served request, or a mask change does not alter them.
- R6: `dev_ack` is one-hot during a service, with bit n set for channel n, and all zero when idle. It rises in the cycle after an edge that sees `hold_ack` high with `pending` high.
- R7: `pending` is the combinational OR over all channels of (device request OR software request) AND NOT mask.
- R8: `svc_done` during a service drops all acknowledges in the next cycle. A new grant needs a later edge with `hold_ack` and `pending` both high.
- R9: No grant is taken while `hold_ack` is low, whatever requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | NCH | Device request lines, active high |
| sw_req_set | input | NCH | Per-channel set strobes for the software request register |
| mask_load | input | 1 | Load `mask_wdata` into the mask register |
| mask_wdata | input | NCH | New mask value; a 1 blocks the channel |
| hold_ack | input | 1 | Bus has been handed over by the processor |
| svc_done | input | 1 | End of the current service |
| pending | output | 1 | An unmasked request exists |
| dev_ack | output | NCH | One-hot acknowledge to the served device |
| grant_idx | output | $clog2(NCH) | Number of the served channel |

## Verification
The bench first keeps all device requests asserted through reset and the following cycles. A design that left the mask clear after reset would raise `pending` there. It then raises channel 0 while channel 1 is being served and also withdraws channel 1's request. A design that re-arbitrated every cycle would move the acknowledge, and one that dropped the grant with the request would release early.

Software requests are served and then checked for clearing. A design that never cleared the bit would keep `pending` high after `svc_done`. Further cases cover a masked channel 0 with a request, and requests held while `hold_ack` is low. These catch a mask applied after the priority encoder and a grant taken without the bus.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic {
      ARB_IDLE  = 1'b0,
      ARB_SERVE = 1'b1
   } arb_state_e;
endpackage

// File: rtl/dma_arb_regs.sv
// Mask and software request registers of the arbiter.
module dma_arb_regs #(
   parameter int NCH = 4,
   localparam int CW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mask_load,
   input  logic [NCH-1:0] mask_wdata,
   input  logic [NCH-1:0] sw_set,
   input  logic           clr_en,
   input  logic [CW-1:0]  clr_idx,
   output logic [NCH-1:0] mask_q,
   output logic [NCH-1:0] swreq_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '1;
      else if (mask_load) mask_q <= mask_wdata;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_swreq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            swreq_q[c] <= 1'b0;
         else if (sw_set[c])
            swreq_q[c] <= 1'b1;
         else if (clr_en && (clr_idx == CW'(c)))
            swreq_q[c] <= 1'b0;
      end
   end

   // R4: ending a service clears that channel's software request
   assert_swreq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !sw_set[clr_idx]) |=> !swreq_q[$past(clr_idx)]);

   // R2: a mask write is visible after the next edge
   assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_load |=> (mask_q == $past(mask_wdata)));

endmodule

// File: rtl/dma_arb_prio.sv
// Priority encoder over the effective requests; the variant picks the winning end.
module dma_arb_prio #(
   parameter int NCH       = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CW-1:0]  idx
);

   assign any = |req;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         idx = '0;
         for (int i = NCH - 1; i >= 0; i--)
            if (req[i]) idx = CW'(i);
      end
   end else begin : g_high_first
      always_comb begin
         idx = '0;
         for (int i = 0; i < NCH; i++)
            if (req[i]) idx = CW'(i);
      end
   end

   always_comb begin
      if (any) assert_idx_requests_R3: assert (req[idx]);
   end

endmodule

// File: rtl/dma_arb_grant.sv
// Grant latch: takes the winner on hold acknowledge, keeps it until done.
module dma_arb_grant
   import dma_arb_pkg::*;
#(
   parameter int NCH = 4,
   localparam int CW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold_ack,
   input  logic           svc_done,
   input  logic           req_any,
   input  logic [CW-1:0]  req_idx,
   output logic           busy,
   output logic [CW-1:0]  grant_idx,
   output logic [NCH-1:0] ack,
   output logic           clr_en
);

   arb_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ARB_IDLE;
         grant_idx <= '0;
      end else begin
         case (state_q)
            ARB_IDLE:
               if (hold_ack && req_any) begin
                  state_q   <= ARB_SERVE;
                  grant_idx <= req_idx;
               end
            ARB_SERVE:
               if (svc_done) state_q <= ARB_IDLE;
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign busy   = (state_q == ARB_SERVE);
   assign clr_en = busy && svc_done;

   for (genvar c = 0; c < NCH; c++) begin : g_ack
      assign ack[c] = busy && (grant_idx == CW'(c));
   end

   // R6: acknowledge never names two channels
   assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));

   // R5: grant held for the whole service
   assert_grant_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !svc_done) |=> (busy && $stable(grant_idx)));

   // R8: done releases the grant
   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && svc_done) |=> !busy);

   // R9: a grant starts only with the bus handed over
   assert_grant_needs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hold_ack));

endmodule

// File: rtl/dma_chan_arb.sv
// Top: request merge, masking, priority and latched grant.
module dma_chan_arb #(
   parameter int NCH       = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] dev_req,
   input  logic [NCH-1:0] sw_req_set,
   input  logic           mask_load,
   input  logic [NCH-1:0] mask_wdata,
   input  logic           hold_ack,
   input  logic           svc_done,
   output logic           pending,
   output logic [NCH-1:0] dev_ack,
   output logic [CW-1:0]  grant_idx
);

   if (NCH < 2) begin : g_bad_nch
      $error("dma_chan_arb: NCH must be at least 2");
   end

   logic [NCH-1:0] mask_q, swreq_q, eff_req;
   logic [CW-1:0]  win_idx;
   logic           busy, clr_en;

   dma_arb_regs #(.NCH(NCH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_load  (mask_load),
      .mask_wdata (mask_wdata),
      .sw_set     (sw_req_set),
      .clr_en     (clr_en),
      .clr_idx    (grant_idx),
      .mask_q     (mask_q),
      .swreq_q    (swreq_q)
   );

   assign eff_req = (dev_req | swreq_q) & ~mask_q;

   dma_arb_prio #(.NCH(NCH), .LOW_FIRST(LOW_FIRST)) u_prio (
      .req (eff_req),
      .any (pending),
      .idx (win_idx)
   );

   dma_arb_grant #(.NCH(NCH)) u_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_ack  (hold_ack),
      .svc_done  (svc_done),
      .req_any   (pending),
      .req_idx   (win_idx),
      .busy      (busy),
      .grant_idx (grant_idx),
      .ack       (dev_ack),
      .clr_en    (clr_en)
   );

   // R2: a new acknowledge always names a channel that was unmasked and requesting
   assert_grant_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ((dev_ack & $past(eff_req)) != '0));

   // R3: no lower-numbered channel was requesting when the grant was taken
   if (LOW_FIRST) begin : g_prio_chk
      assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy) |-> (($past(eff_req) & (dev_ack - 1'b1)) == '0));
   end

endmodule

// File: tb/dma_chan_arb_bench.sv
module dma_chan_arb_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW  = $clog2(NCH);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] dev_req = '0, sw_req_set = '0, mask_wdata = '0;
   logic           mask_load = 1'b0, hold_ack = 1'b0, svc_done = 1'b0;
   logic           pending;
   logic [NCH-1:0] dev_ack;
   logic [CW-1:0]  grant_idx;

   dma_chan_arb #(.NCH(NCH)) u_dma_chan_arb (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .sw_req_set(sw_req_set),
      .mask_load(mask_load), .mask_wdata(mask_wdata), .hold_ack(hold_ack),
      .svc_done(svc_done), .pending(pending), .dev_ack(dev_ack), .grant_idx(grant_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [NCH-1:0] ack;
      logic           pend;
      string          tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;

   // reference state built from the requirements
   logic [NCH-1:0] m_mask = '1, m_sw = '0;
   logic           m_busy = 1'b0;
   int             m_win  = 0;

   function automatic int lowest(input logic [NCH-1:0] v);
      for (int i = NCH - 1; i >= 0; i--) if (v[i]) lowest = i;
      if (v == '0) lowest = 0;
   endfunction

   task automatic drive(input logic [NCH-1:0] req, input logic [NCH-1:0] set,
                        input logic mld, input logic [NCH-1:0] mdat,
                        input logic hold, input logic done, input string tag);
      logic [NCH-1:0] eff;
      exp_t e;
      @(negedge clk);
      dev_req = req; sw_req_set = set; mask_load = mld; mask_wdata = mdat;
      hold_ack = hold; svc_done = done;
      eff = (req | m_sw) & ~m_mask;
      if (!m_busy) begin
         if (hold && eff != '0) begin m_busy = 1'b1; m_win = lowest(eff); end
      end else if (done) begin
         m_busy = 1'b0;
         m_sw[m_win] = 1'b0;
      end
      m_sw = m_sw | set;
      if (mld) m_mask = mdat;
      e.ack  = m_busy ? (NCH'(1) << m_win) : '0;
      e.pend = |((req | m_sw) & ~m_mask);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compare a quarter period after each edge, inputs still stable
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (dev_ack !== e.ack) begin
            n_errors++;
            $display("FAIL %s: dev_ack actual %b expected %b", e.tag, dev_ack, e.ack);
         end
         if (pending !== e.pend) begin
            n_errors++;
            $display("FAIL %s: pending actual %b expected %b", e.tag, pending, e.pend);
         end
         if (e.ack != '0 && grant_idx !== CW'(lowest(e.ack))) begin
            n_errors++;
            $display("FAIL %s: grant_idx actual %0d expected %0d", e.tag, grant_idx, lowest(e.ack));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      dev_req = '1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: mask set after reset, requests blocked
      drive(4'b1111, 4'b0000, 0, 4'b0000, 1, 0, "R1 reset mask");
      drive(4'b1111, 4'b0000, 0, 4'b0000, 1, 0, "R1 reset idle");
      // R7: unmask everything
      drive(4'b0000, 4'b0000, 1, 4'b0000, 0, 0, "R7 unmask no req");
      drive(4'b0100, 4'b0000, 0, 4'b0000, 0, 0, "R7 pending hw");
      // R9: requests without bus
      drive(4'b0110, 4'b0000, 0, 4'b0000, 0, 0, "R9 no hold");
      drive(4'b0110, 4'b0000, 0, 4'b0000, 0, 0, "R9 no hold 2");
      // R3 / R6: grant ch1
      drive(4'b0110, 4'b0000, 0, 4'b0000, 1, 0, "R3 R6 grant ch1");
      // R5: higher request appears, served request drops, mask changes
      drive(4'b0111, 4'b0000, 0, 4'b0000, 1, 0, "R5 hold against ch0");
      drive(4'b0101, 4'b0000, 0, 4'b0000, 1, 0, "R5 request withdrawn");
      drive(4'b0101, 4'b0000, 1, 4'b0010, 1, 0, "R5 mask change");
      drive(4'b0101, 4'b0000, 1, 4'b0000, 1, 0, "R5 still held");
      // R8: release then regrant ch0
      drive(4'b0101, 4'b0000, 0, 4'b0000, 0, 1, "R8 release");
      drive(4'b0101, 4'b0000, 0, 4'b0000, 0, 0, "R8 idle no hold");
      drive(4'b0101, 4'b0000, 0, 4'b0000, 1, 0, "R8 regrant ch0");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 0, 1, "R8 release ch0");
      // R2: ch0 masked, ch1 wins
      drive(4'b0011, 4'b0000, 1, 4'b0001, 0, 0, "R2 mask ch0");
      drive(4'b0001, 4'b0000, 0, 4'b0000, 1, 0, "R2 masked only req");
      drive(4'b0011, 4'b0000, 0, 4'b0000, 1, 0, "R2 R3 skip masked ch0");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 0, 1, "R2 release");
      // R4: software request on ch3
      drive(4'b0000, 4'b1000, 1, 4'b0000, 0, 0, "R4 sw set ch3");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 0, 0, "R4 sw pending");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 1, 0, "R4 sw grant ch3");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 1, 1, "R4 sw cleared at done");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 1, 0, "R4 no regrant");
      // R4 / R2: masked software request stays silent
      drive(4'b0000, 4'b0100, 1, 4'b0100, 0, 0, "R4 sw set ch2 masked");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 1, 0, "R2 masked sw ignored");
      drive(4'b0000, 4'b0000, 1, 4'b0000, 1, 0, "R4 unmask sw ch2");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 1, 0, "R4 R6 sw grant ch2");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 0, 1, "R4 release ch2");
      drive(4'b0000, 4'b0000, 0, 4'b0000, 0, 0, "R6 idle ack low");
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule